// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external static RAM that has no clock of its own: 32K words of 8 bits behind a 15-bit address, an 8-bit shared data bus and three active-low strobes (chip select, output enable, write enable). The user side is a request/ready handshake carrying a read/write flag, an address and write data. Each read returns its data together with a single-cycle valid pulse. The memory's minimum times are given in nanoseconds as parameters, together with the clock period. Each one becomes a whole number of cycles, rounded up and never below one cycle when the time is nonzero. The controller then holds every strobe phase for that many cycles.

The shared data bus is brought out as three signals for the pad cell: the value to drive, a drive enable and the value seen on the pins. The controller drives the bus only while writing. When no request is pending it parks in standby, with chip select high.

The sequencer has seven states. `ST_IDLE` takes a request. On a write, `ST_IDLE -> ST_WR_SETUP` (address set up, strobes inactive), then `ST_WR_SETUP -> ST_WR_PULSE` (write strobe low, bus driven), then `ST_WR_PULSE -> ST_WR_HOLD` when the pulse count expires (write strobe high, bus still driven). From there it goes `ST_WR_HOLD -> ST_WR_PAD` if the full write cycle needs more time, otherwise `ST_WR_HOLD -> ST_IDLE`, and `ST_WR_PAD -> ST_IDLE` when the padding expires. On a read, `ST_IDLE -> ST_RD_ACCESS` (chip select and output enable low), then `ST_RD_ACCESS -> ST_RD_TURN` when the access count expires, capturing the data on that edge. Last comes `ST_RD_TURN -> ST_IDLE` once the bus-release count expires.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, all three strobes are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: With no request pending, mem_ce_n stays 1 and req_ready stays 1. req_ready is 0 from the cycle after a request is taken until the transaction ends.
- R3: A write starts with one setup cycle (mem_ce_n=0, mem_we_n=1, mem_oe_n=1). Then mem_we_n is 0 for WP = max(ceil(write pulse/period), ceil(data overlap/period), 1) cycles, which is 4 at the defaults. mem_oe_n stays 1 throughout a write.
- R4: mem_dq_oe is 1 exactly from the first write-strobe-low cycle through the first cycle after mem_we_n returns to 1, and 0 at every other time. While it is 1, mem_dq_o equals the request's write data.
- R5: A write keeps mem_ce_n at 0 for max(WP+2, ceil(write cycle/period)) cycles, which is 6 at the defaults. req_ready is 1 again in the cycle right after chip select rises, 6 cycles after the accepting edge.
- R6: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for ACC = max(ceil(address access/period), ceil(output-enable access/period), 1) cycles, which is 6 at the defaults.
- R7: The data bus is sampled on the edge that ends the last access cycle. rsp_valid is 1 for exactly one cycle after that edge, 6 cycles after the accepting edge, and rsp_rdata then carries the sampled byte.
- R8: After a read, mem_ce_n and mem_oe_n are 1 and mem_dq_oe is 0 for HZ = max(ceil(bus release/period), 1) cycles (2 at the defaults) before req_ready returns. The bus is never driven within HZ cycles of output enable rising.
- R9: mem_addr holds the request's address and stays unchanged for as long as mem_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and taking a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: rsp_rdata holds read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Address to memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Value for the data pads to drive |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_i | input | 8 | Value seen on the data pads |

## Verification
Cycles are counted from the rising edge on which the request is taken, and every check samples on the falling edge after that many rising edges. The setup strobes are due in cycle 0 and the first write-strobe-low cycle and bus drive in cycle 1. Write completion and the return of ready fall in cycle 6. The read-data pulse is due in cycle 6, and ready after a read in cycle 8. The bench records the first cycle in which each event appears and compares it with these figures, which it works out from the requirement formulas. Its memory model supplies valid read data only after ACC-1 edges of continuous read mode, so early sampling is visible at rsp_rdata. The model also flags drive conflicts, short write pulses and address changes while chip select is low.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_PULSE  = 3'd2,
        ST_WR_HOLD   = 3'd3,
        ST_WR_PAD    = 3'd4,
        ST_RD_ACCESS = 3'd5,
        ST_RD_TURN   = 3'd6
    } ctrl_state_e;

    // Nanoseconds to whole clock cycles, rounded up; zero stays zero.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        if (ns <= 0) return 0;
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

    // Counter never wraps below zero (R3 pulse length depends on it)
    assert_timer_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remain_q == '0) |=> (remain_q == '0));

endmodule

// File: rtl/sram_bus_datapath.sv
module sram_bus_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              drive,
    input  logic              capture,
    input  logic [DATA_W-1:0] pad_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            rd_valid <= capture;
            if (capture) begin
                rd_data <= pad_in;
            end
        end
    end

    assign addr_out = addr_q;
    assign pad_out  = wdata_q;
    assign pad_oe   = drive;

    // Read result is a single-cycle pulse (R7)
    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // Write data register cannot change while the pads are driven (R4)
    assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && $past(pad_oe)) |-> $stable(pad_out));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W         = 15,
    parameter int DATA_W         = 8,
    parameter int CLK_PERIOD_NS  = 10,
    parameter int WR_PULSE_NS    = 40,
    parameter int WR_DATA_NS     = 25,
    parameter int WR_CYCLE_NS    = 55,
    parameter int RD_ACCESS_NS   = 55,
    parameter int RD_OE_NS       = 30,
    parameter int BUS_RELEASE_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int WP_CYC  = imax(imax(ns_to_cyc(WR_PULSE_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(WR_DATA_NS, CLK_PERIOD_NS)), 1);
    localparam int ACC_CYC = imax(imax(ns_to_cyc(RD_ACCESS_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(RD_OE_NS, CLK_PERIOD_NS)), 1);
    localparam int HZ_CYC  = imax(ns_to_cyc(BUS_RELEASE_NS, CLK_PERIOD_NS), 1);
    localparam int WC_CYC  = ns_to_cyc(WR_CYCLE_NS, CLK_PERIOD_NS);
    localparam int PAD_CYC = (WC_CYC > WP_CYC + 2) ? (WC_CYC - WP_CYC - 2) : 0;
    localparam int MAX_CYC = imax(imax(WP_CYC, ACC_CYC), imax(HZ_CYC, PAD_CYC));
    localparam int TW      = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] WP_LD  = TW'(WP_CYC - 1);
    localparam logic [TW-1:0] ACC_LD = TW'(ACC_CYC - 1);
    localparam logic [TW-1:0] HZ_LD  = TW'(HZ_CYC - 1);
    localparam logic [TW-1:0] PAD_LD = TW'(imax(PAD_CYC, 1) - 1);

    ctrl_state_e   state_q, state_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          accept;
    logic          capture;
    logic          drive;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state and timer loads ----------------
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = ACC_LD;
                    end
                end
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                if (PAD_CYC > 0) begin
                    state_d  = ST_WR_PAD;
                    tmr_load = 1'b1;
                    tmr_val  = PAD_LD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_PAD: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    capture  = 1'b1;
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = HZ_LD;
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- strobe decode ----------------
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        drive     = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_WR_SETUP: begin
                mem_ce_n = 1'b0;
            end
            ST_WR_PULSE: begin
                mem_ce_n = 1'b0;
                mem_we_n = 1'b0;
                drive    = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_ce_n = 1'b0;
                drive    = 1'b1;
            end
            ST_WR_PAD: begin
                mem_ce_n = 1'b0;
            end
            ST_RD_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_RD_TURN: begin
                req_ready = 1'b0;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    sram_phase_timer #(
        .W(TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_bus_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .drive    (drive),
        .capture  (capture),
        .pad_in   (mem_dq_i),
        .addr_out (mem_addr),
        .pad_out  (mem_dq_o),
        .pad_oe   (mem_dq_oe),
        .rd_valid (rsp_valid),
        .rd_data  (rsp_rdata)
    );

    // ---------------- checker state and assertions ----------------
    logic [TW-1:0] chk_we_low;
    logic [TW-1:0] chk_oe_high;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_we_low  <= '0;
            chk_oe_high <= TW'(HZ_CYC);
        end else begin
            chk_we_low <= mem_we_n ? '0 : chk_we_low + 1'b1;
            if (!mem_oe_n) begin
                chk_oe_high <= '0;
            end else if (chk_oe_high != TW'(HZ_CYC)) begin
                chk_oe_high <= chk_oe_high + 1'b1;
            end
        end
    end

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && chk_we_low != '0) |-> (chk_we_low >= TW'(WP_CYC)));

    assert_no_oe_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n) |-> mem_oe_n);

    assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

    assert_drive_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |-> mem_dq_oe);

    assert_idle_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

    assert_rsp_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    assert_bus_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (chk_oe_high >= TW'(HZ_CYC)));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

    // Cycle counts from the requirement formulas at 10 ns:
    // WP = ceil(40/10)=4, ACC = ceil(55/10)=6, HZ = ceil(20/10)=2, write CE-low = 6
    localparam int WP   = 4;
    localparam int ACC  = 6;
    localparam int HZ   = 2;
    localparam int WCL  = 6;
    localparam logic [7:0] GARBAGE = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_i;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sram_async_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] model_mem [logic [14:0]];
    int rd_age = 0;
    int we_run = 0;
    int oe_high_run = 100;
    logic [14:0] ce_addr = '0;
    logic        ce_prev = 1'b1;

    function automatic logic [7:0] mem_peek(input logic [14:0] a);
        if (model_mem.exists(a)) return model_mem[a];
        return 8'h00;
    endfunction

    wire rd_mode = !mem_ce_n && !mem_oe_n && mem_we_n;

    always @* begin
        if (rd_mode && rd_age >= ACC - 1) mem_dq_i = mem_peek(mem_addr);
        else mem_dq_i = GARBAGE;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            // R9: address steady while chip select low
            if (!mem_ce_n && !ce_prev && mem_addr != ce_addr)
                check(1'b0, "R9", "address moved under chip select", mem_addr, ce_addr);
            if (!mem_ce_n) ce_addr = mem_addr;
            // R4/R8: drive conflicts and turnaround
            if (mem_dq_oe && !mem_oe_n)
                check(1'b0, "R4", "bus drive during output enable", 1, 0);
            if (mem_dq_oe && oe_high_run < HZ)
                check(1'b0, "R8", "drive too soon after output enable", oe_high_run, HZ);
            if (!mem_ce_n && !mem_we_n) begin
                we_run++;
                if (!mem_dq_oe) check(1'b0, "R4", "write pulse without drive", 0, 1);
            end else if (we_run > 0) begin
                check(we_run >= WP, "R3", "write pulse width", we_run, WP);
                check(mem_dq_oe, "R4", "data hold after write strobe", mem_dq_oe, 1);
                model_mem[mem_addr] = mem_dq_o;
                we_run = 0;
            end
        end
        ce_prev = mem_ce_n;
        rd_age = rd_mode ? rd_age + 1 : 0;
        oe_high_run = mem_oe_n ? oe_high_run + 1 : 0;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- one transaction ----------------
    task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                          input bit check_data);
        int first_rsp = -1;
        int first_rdy = -1;
        int rsp_cnt = 0;
        int ce_low = 0;
        int waited = 0;
        logic [7:0] got = '0;
        while (!req_ready && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check(req_ready, "R2", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // cycle 0
        check(!req_ready, "R2", "ready low in transaction", req_ready, 0);
        check(mem_addr == a, "R9", "address presented", mem_addr, a);
        if (wr) begin
            check(!mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R3",
                  "setup cycle strobes ce/we/oe/oe_dq",
                  {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
        end else begin
            check(!mem_ce_n && !mem_oe_n && mem_we_n, "R6", "read strobes ce/oe/we",
                  {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
        end
        if (!mem_ce_n) ce_low++;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (rsp_valid) begin
                rsp_cnt++;
                if (first_rsp < 0) begin
                    first_rsp = k;
                    got = rsp_rdata;
                end
            end
            if (!mem_ce_n) ce_low++;
            if (wr && k == 1)
                check(!mem_we_n && mem_dq_oe && mem_dq_o == d, "R4",
                      "first pulse cycle drive/data", mem_dq_o, d);
            if (wr && k == WP + 1)
                check(mem_we_n && mem_dq_oe, "R4", "hold cycle drive",
                      {mem_we_n, mem_dq_oe}, 2'b11);
            if (!wr && k == ACC)
                check(mem_ce_n && mem_oe_n && !mem_dq_oe, "R8", "turnaround strobes",
                      {mem_ce_n, mem_oe_n, mem_dq_oe}, 3'b110);
            if (!wr && k < ACC)
                check(!mem_oe_n && !mem_ce_n, "R6", "access held", {mem_ce_n, mem_oe_n}, 0);
            if (req_ready) begin
                first_rdy = k;
                break;
            end
        end
        if (wr) begin
            check(ce_low == WCL, "R5", "write chip-select-low cycles", ce_low, WCL);
            check(first_rdy == WCL, "R5", "ready after write", first_rdy, WCL);
            check(rsp_cnt == 0, "R7", "no read pulse on write", rsp_cnt, 0);
        end else begin
            check(first_rsp == ACC, "R7", "read valid cycle", first_rsp, ACC);
            check(rsp_cnt == 1, "R7", "read valid pulse count", rsp_cnt, 1);
            check(ce_low == ACC, "R6", "read chip-select-low cycles", ce_low, ACC);
            check(first_rdy == ACC + HZ, "R8", "ready after read", first_rdy, ACC + HZ);
            if (check_data)
                check(got == d, "R7", "read data", got, d);
        end
    endtask

    // {write, addr[14:0], data-or-expected[7:0]}
    localparam int NV = 13;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 15'h0000, 8'h3C},
        {1'b1, 15'h7FFF, 8'hC3},
        {1'b0, 15'h0000, 8'h3C},
        {1'b0, 15'h7FFF, 8'hC3},
        {1'b1, 15'h1234, 8'hA5},
        {1'b0, 15'h1234, 8'hA5},
        {1'b1, 15'h1234, 8'h5A},
        {1'b0, 15'h1234, 8'h5A},
        {1'b0, 15'h0001, 8'h00},
        {1'b1, 15'h4000, 8'hFF},
        {1'b0, 15'h4000, 8'hFF},
        {1'b1, 15'h0001, 8'h01},
        {1'b0, 15'h0001, 8'h01}
    };

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
              "R1", "outputs in reset",
              {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
              "R1", "outputs after reset",
              {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);

        // R2: standby while no request
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(mem_ce_n && req_ready, "R2", "idle standby",
                  {mem_ce_n, req_ready}, 2'b11);
        end

        // table walk, requests issued back to back
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][23], VEC[v][22:8], VEC[v][7:0], 1'b1);
        end

        // R2: standby again after traffic
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(mem_ce_n && req_ready && !mem_dq_oe, "R2", "idle after traffic",
                  {mem_ce_n, req_ready, mem_dq_oe}, 3'b110);
        end

        // read-then-write-then-read at top address with turnaround
        run_op(1'b0, 15'h7FFF, 8'hC3, 1'b1);
        run_op(1'b1, 15'h7FFF, 8'h96, 1'b0);
        run_op(1'b0, 15'h7FFF, 8'h96, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule